// File: doc/BRIEF.md
# ECC Chunk Status Accumulator

After a page has gone through the BCH decoder, the decoder leaves one status byte per 512-byte chunk in an auxiliary buffer. This block walks those bytes and reduces them to page-level results. It reports the total number of corrected bitflips, the number of chunks that could not be corrected, and whether every chunk of the page reads as erased.

Software or a page-read sequencer gives the page data size and pulses `start_i`. The block then reads the status bytes through a one-cycle-latency byte port. The bytes sit directly after a metadata field of 10 bytes, and that field is padded up to the next 4-byte boundary. The block issues one address per cycle. When the last byte has been counted, it raises `done_o` for one cycle, and the totals are valid on that cycle. The totals then hold until the next accepted start.

Top module: `ecc_status_scan`

## Requirements
- R1: The number of chunks scanned is the page size divided by 512, rounded down and limited to `MAX_CHUNKS` (16 by default). Exactly one status byte is read per chunk.
- R2: Status bytes are read from consecutive addresses starting at byte 12 of the auxiliary buffer, one per cycle. `rd_en_o` is high only for those reads.
- R3: A status byte of 0x00 (clean chunk) leaves both totals unchanged.
- R4: A status byte of 0xFF (erased chunk) leaves both totals unchanged. `all_erased_o` is 1 at done only when at least one chunk was scanned and every scanned status was 0xFF.
- R5: A status byte of 0xFE (uncorrectable chunk) adds one to `failed_o`.
- R6: Any other status value is a count of corrected bits and is added to `corrected_o`.
- R7: `corrected_o` saturates at 2^CORR_W−1 and never wraps.
- R8: An accepted start clears both totals. For n>0 chunks, `busy_o` is high for the n+1 cycles after the start edge. `done_o` is high for exactly one cycle, the cycle right after that, and `busy_o` is low on that cycle.
- R9: A page smaller than 512 bytes causes no reads. `done_o` pulses on the cycle after the start, with zero totals and `all_erased_o` low.
- R10: A start pulse while `busy_o` is high is ignored. The scan in progress and its totals are not disturbed.
- R11: After reset, `busy_o`, `done_o`, `rd_en_o` and all totals are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a scan (accepted when not busy) |
| page_bytes_i | input | PAGE_W | Page data size in bytes, sampled at start |
| rd_en_o | output | 1 | Status byte read request |
| rd_addr_o | output | ADDR_W | Auxiliary buffer byte address |
| rd_data_i | input | 8 | Read data, one cycle after the request |
| corrected_o | output | CORR_W | Total corrected bits (saturating) |
| failed_o | output | FAIL_W | Number of uncorrectable chunks |
| all_erased_o | output | 1 | Every scanned chunk was erased |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the three reserved codes placed next to ordinary counts. A decoder that confuses 0xFE or 0xFF with a bit count would inflate `corrected_o` by 254 or 255. It also checks a page whose bitflips overflow a narrowed corrected total, where a wrapping adder would report a small number. A sub-chunk page is scanned, where an off-by-one sequencer would read a stray byte or never finish. A page larger than the limit is scanned, where a missing clamp would run past byte 27 and pick up a planted 0xFE. Finally, a start is held high during a scan, where a block that does not ignore it would restart and clear its totals.

// File: rtl/ecc_scan_pkg.sv
// Shared status codes and classification for the chunk status scanner.
package ecc_scan_pkg;
    localparam logic [7:0] ST_CLEAN  = 8'h00;
    localparam logic [7:0] ST_ERASED = 8'hFF;
    localparam logic [7:0] ST_FAIL   = 8'hFE;

    typedef enum logic [1:0] {
        K_CLEAN  = 2'd0,
        K_ERASED = 2'd1,
        K_FAIL   = 2'd2,
        K_FIXED  = 2'd3
    } stat_kind_e;

    // Map one status byte to its meaning.
    function automatic stat_kind_e classify(input logic [7:0] b);
        if (b == ST_CLEAN)       return K_CLEAN;
        else if (b == ST_ERASED) return K_ERASED;
        else if (b == ST_FAIL)   return K_FAIL;
        else                     return K_FIXED;
    endfunction
endpackage

// File: rtl/ecc_scan_seq.sv
// Sequencer for the status scan.
// Latches the chunk count at an accepted start and issues one read per cycle
// from STAT_BASE onward. It tracks the one-cycle read latency and ends the
// scan once the last returned byte has been consumed.
// Assumes the read port returns data exactly one cycle after rd_en_o.
module ecc_scan_seq #(
    parameter int PAGE_W      = 14,
    parameter int CHUNK_SHIFT = 9,
    parameter int MAX_CHUNKS  = 16,
    parameter int CNT_W       = 5,
    parameter int ADDR_W      = 8,
    parameter int STAT_BASE   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_bytes_i,
    output logic              accept_o,
    output logic              empty_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              vld_o
);
    logic [CNT_W-1:0]  n_q, iss_q, n_clamp;
    logic [PAGE_W-1:0] n_raw;
    logic              busy_q, done_q, vld_q;

    // Chunk count from page size, clamped to the supported maximum.
    always_comb begin
        n_raw = page_bytes_i >> CHUNK_SHIFT;
        if (n_raw > PAGE_W'(MAX_CHUNKS)) n_clamp = CNT_W'(MAX_CHUNKS);
        else                             n_clamp = n_raw[CNT_W-1:0];
    end

    assign accept_o  = start_i && !busy_q;
    assign empty_o   = accept_o && (n_clamp == '0);
    assign rd_en_o   = busy_q && (iss_q < n_q);
    assign rd_addr_o = ADDR_W'(STAT_BASE) + ADDR_W'(iss_q);
    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign vld_o     = vld_q;

    // Scan control: latch count, step the address, finish after last data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= '0;
            iss_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            vld_q  <= rd_en_o;
            if (accept_o) begin
                n_q    <= n_clamp;
                iss_q  <= '0;
                busy_q <= (n_clamp != '0);
                done_q <= (n_clamp == '0);
            end else if (busy_q) begin
                if (rd_en_o) iss_q <= iss_q + 1'b1;
                if (iss_q == n_q && vld_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/ecc_scan_acc.sv
// Accumulator for the status scan.
// Folds each returned status byte into the page totals. The corrected total
// saturates. The erased flag stays set only while every byte is 0xFF.
// Assumes clear_i and vld_i are never high in the same cycle.
module ecc_scan_acc
    import ecc_scan_pkg::*;
#(
    parameter int CORR_W = 16,
    parameter int FAIL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              zero_i,
    input  logic              vld_i,
    input  logic [7:0]        data_i,
    output logic [CORR_W-1:0] corrected_o,
    output logic [FAIL_W-1:0] failed_o,
    output logic              all_erased_o
);
    logic [CORR_W-1:0] corr_q;
    logic [FAIL_W-1:0] fail_q;
    logic              er_q;
    logic [CORR_W:0]   sum;
    logic [CORR_W-1:0] corr_sat;

    // Saturating add of the current byte to the corrected total.
    always_comb begin
        sum      = {1'b0, corr_q} + (CORR_W+1)'(data_i);
        corr_sat = sum[CORR_W] ? '1 : sum[CORR_W-1:0];
    end

    // Update totals per returned status byte; clear on accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr_q <= '0;
            fail_q <= '0;
            er_q   <= 1'b0;
        end else if (clear_i) begin
            corr_q <= '0;
            fail_q <= '0;
            er_q   <= !zero_i;
        end else if (vld_i) begin
            unique case (classify(data_i))
                K_CLEAN:  er_q <= 1'b0;
                K_ERASED: er_q <= er_q;
                K_FAIL: begin
                    fail_q <= fail_q + 1'b1;
                    er_q   <= 1'b0;
                end
                K_FIXED: begin
                    corr_q <= corr_sat;
                    er_q   <= 1'b0;
                end
            endcase
        end
    end

    assign corrected_o  = corr_q;
    assign failed_o     = fail_q;
    assign all_erased_o = er_q;
endmodule

// File: rtl/ecc_status_scan.sv
// Top of the ECC chunk status accumulator.
// Combines the read sequencer and the accumulator. Status bytes start after
// the metadata field, which is rounded up to a 4-byte boundary.
// Assumes a one-cycle-latency byte read port into the auxiliary buffer.
module ecc_status_scan #(
    parameter int PAGE_W      = 14,
    parameter int CHUNK_BYTES = 512,
    parameter int META_BYTES  = 10,
    parameter int MAX_CHUNKS  = 16,
    parameter int ADDR_W      = 8,
    parameter int CORR_W      = 16,
    parameter int FAIL_W      = $clog2(MAX_CHUNKS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [PAGE_W-1:0] page_bytes_i,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic [CORR_W-1:0] corrected_o,
    output logic [FAIL_W-1:0] failed_o,
    output logic              all_erased_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int CHUNK_SHIFT = $clog2(CHUNK_BYTES);
    localparam int STAT_BASE   = ((META_BYTES + 3) / 4) * 4;
    localparam int CNT_W       = $clog2(MAX_CHUNKS + 1);

    logic accept, empty, vld;

    ecc_scan_seq #(
        .PAGE_W(PAGE_W), .CHUNK_SHIFT(CHUNK_SHIFT), .MAX_CHUNKS(MAX_CHUNKS),
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_bytes_i(page_bytes_i),
        .accept_o(accept), .empty_o(empty), .busy_o(busy_o), .done_o(done_o),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .vld_o(vld)
    );

    ecc_scan_acc #(.CORR_W(CORR_W), .FAIL_W(FAIL_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear_i(accept), .zero_i(empty),
        .vld_i(vld), .data_i(rd_data_i), .corrected_o(corrected_o),
        .failed_o(failed_o), .all_erased_o(all_erased_o)
    );
endmodule

// File: rtl/ecc_scan_chk.sv
// Checker for the status scanner, bound to every ecc_status_scan instance.
// Relates the port handshakes and the totals over time.
module ecc_scan_chk #(
    parameter int PAGE_W = 14,
    parameter int ADDR_W = 8,
    parameter int CORR_W = 16,
    parameter int FAIL_W = 5,
    parameter int BASE   = 12,
    parameter int MAXC   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [PAGE_W-1:0] page_bytes_i,
    input logic              rd_en_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic [7:0]        rd_data_i,
    input logic [CORR_W-1:0] corrected_o,
    input logic [FAIL_W-1:0] failed_o,
    input logic              all_erased_o,
    input logic              busy_o,
    input logic              done_o
);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    p_read_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_addr_o >= ADDR_W'(BASE)) && (rd_addr_o < ADDR_W'(BASE + MAXC)));
    p_read_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);
    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> rd_en_o && rd_addr_o == ADDR_W'(BASE));
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o) && $past(busy_o)) |-> rd_addr_o == $past(rd_addr_o) + 1'b1);
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> corrected_o >= $past(corrected_o));
    p_fail_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (failed_o == $past(failed_o) || failed_o == $past(failed_o) + 1'b1));
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && $past(start_i)) |-> failed_o >= $past(failed_o));
endmodule

bind ecc_status_scan ecc_scan_chk #(
    .PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CORR_W(CORR_W), .FAIL_W(FAIL_W),
    .BASE(((META_BYTES + 3) / 4) * 4), .MAXC(MAX_CHUNKS)
) u_chk (.*);

// File: tb/ecc_status_scan_tb_top.sv
`timescale 1ns/1ps
module ecc_status_scan_tb_top;
    localparam int PAGE_W = 14;
    localparam int ADDR_W = 8;
    localparam int CORR_W = 10;
    localparam int FAIL_W = 5;
    localparam int BASE   = 12;
    localparam int MAXC   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [PAGE_W-1:0] page_bytes = '0;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data = 8'h00;
    logic [CORR_W-1:0] corrected;
    logic [FAIL_W-1:0] failed;
    logic              all_erased, busy, done;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] aux [0:63];

    always #2.5 clk = ~clk;

    ecc_status_scan #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .CORR_W(CORR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .page_bytes_i(page_bytes),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
        .corrected_o(corrected), .failed_o(failed), .all_erased_o(all_erased),
        .busy_o(busy), .done_o(done)
    );

    // Auxiliary buffer: one-cycle read latency, junk when not read.
    always @(posedge clk) rd_data <= rd_en ? aux[rd_addr[5:0]] : 8'h5A;

    // Behavioural reference: post-edge expected busy/done/read state.
    int m_n = 0, m_iss = 0, m_left = 0;
    bit m_busy = 0, m_done = 0;
    always @(posedge clk) begin
        m_done = 0;
        if (!rst_n) begin
            m_busy = 0; m_iss = 0; m_left = 0; m_n = 0;
        end else if (m_busy) begin
            if (m_iss < m_n) m_iss++;
            m_left--;
            if (m_left == 0) begin m_busy = 0; m_done = 1; end
        end else if (start_i) begin
            m_n = int'(page_bytes) / 512;
            if (m_n > MAXC) m_n = MAXC;
            m_iss = 0;
            if (m_n == 0) m_done = 1;
            else begin m_busy = 1; m_left = m_n + 1; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare control outputs against the reference every cycle.
    always @(negedge clk) if (rst_n) begin
        chk(busy == m_busy, "R8 busy", busy, m_busy);
        chk(done == m_done, "R8 done", done, m_done);
        chk(rd_en == (m_busy && m_iss < m_n), "R2 rd_en", rd_en, m_busy && m_iss < m_n);
        if (rd_en) chk(int'(rd_addr) == BASE + m_iss, "R2 addr", rd_addr, BASE + m_iss);
    end

    // Run one scan; hold_extra re-asserts start during the scan.
    task automatic scan(input int page, input bit hold_extra, input string req);
        int n, ec, ef, to;
        bit ee;
        n = page / 512; if (n > MAXC) n = MAXC;
        ec = 0; ef = 0; ee = (n > 0);
        for (int i = 0; i < n; i++) begin
            int b;
            b = aux[BASE + i];
            if (b == 8'hFE) ef++;
            else if (b != 8'h00 && b != 8'hFF) ec += b;
            if (b != 8'hFF) ee = 0;
        end
        if (ec > (1 << CORR_W) - 1) ec = (1 << CORR_W) - 1;
        @(negedge clk);
        page_bytes = PAGE_W'(page);
        start_i = 1'b1;
        @(negedge clk);
        start_i = hold_extra;
        if (hold_extra) begin repeat (2) @(negedge clk); start_i = 1'b0; end
        to = 0;
        while (!done && to < 100) begin @(negedge clk); to++; end
        chk(done, {req, " done seen"}, done, 1);
        chk(int'(corrected) == ec, {req, " corrected"}, corrected, ec);
        chk(int'(failed) == ef, {req, " failed"}, failed, ef);
        chk(all_erased == ee, {req, " erased"}, all_erased, ee);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        for (int i = 0; i < 64; i++) aux[i] = 8'hFE;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(!busy && !done && !rd_en, "R11 control", {busy, done, rd_en}, 0);
        chk(corrected == 0 && failed == 0, "R11 totals", corrected + failed, 0);
        // R3 R5 R6: mixed codes on 4 chunks (erased 0xFF included, R4)
        aux[12] = 8'h00; aux[13] = 8'h03; aux[14] = 8'hFE; aux[15] = 8'hFF;
        scan(2048, 0, "R3 R5 R6");
        // R4: all erased page
        for (int i = 0; i < 8; i++) aux[BASE + i] = 8'hFF;
        scan(4096, 0, "R4");
        // R6: many distinct counts, 8 chunks
        aux[12] = 8'h01; aux[13] = 8'h02; aux[14] = 8'hFE; aux[15] = 8'hFE;
        aux[16] = 8'h00; aux[17] = 8'h10; aux[18] = 8'hFD; aux[19] = 8'h07;
        scan(4096, 0, "R6 R5");
        // R9: sub-chunk page
        scan(300, 0, "R9");
        // R10: start held during a 5-chunk scan (non power of two)
        aux[12] = 8'h04; aux[13] = 8'hFE; aux[14] = 8'h00; aux[15] = 8'h09; aux[16] = 8'hFF;
        scan(2600, 1, "R10");
        // R7: 16 chunks of 253 overflow a 10-bit total
        for (int i = 0; i < 16; i++) aux[BASE + i] = 8'hFD;
        scan(8192, 0, "R7");
        // R1: oversize page clamps to 16 chunks; planted 0xFE beyond must be skipped
        aux[BASE + 16] = 8'hFE; aux[BASE + 17] = 8'hFE;
        for (int i = 0; i < 16; i++) aux[BASE + i] = 8'h00;
        aux[BASE + 15] = 8'h02;
        scan(16000, 0, "R1");
        repeat (3) @(negedge clk);
        summary();
    end
endmodule